// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a 64-bit up-counter with a small register file. It can run as a free-running timer or serve as a system watchdog. The counter advances on the output of a programmable prescaler. It runs only while the run field selects continuous counting and both counter halves are released. Software can load the counter and a 64-bit period as pairs of 32-bit words.

When watchdog mode is selected, software arms the watchdog by writing an ordered pair of 16-bit keys into the upper half of the watchdog control word. After that it must keep repeating the same ordered pair, and each completed pair returns the count to zero. If the count ever reaches the programmed period while the watchdog is armed, the block raises a single-cycle reset request. It also sets a timeout flag that stays set until reset. Once the watchdog is armed, only the block's reset input can disarm it. While it is armed, the configuration, counter and period registers cannot be written.

Register reads return data one cycle after the read strobe. A read of the low counter word also captures the high word, so a following read of the high word yields a consistent 64-bit value.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, every register reads 0, the reset request is low and the watchdog is disarmed.
- R2: The counter advances only while control bits 23:22 equal 2 and global-control bits 1:0 are both 1. Any other combination, including a run field of 0, holds the count.
- R3: Global-control bits starting at bit 8 hold N, and the counter then advances once every N+1 clocks.
- R4: The counter words are written at offset 2 (low) and offset 3 (high). A read of offset 2 returns the live low word and captures the high word. A read of offset 3 returns that captured word.
- R5: Arming requires global-control bits 3:2 equal to 2. Software then writes offset 6 with key 0xA5C6 in bits 31:16 and bit 14 set, followed by key 0xDA7E. The second write clears the counter to 0, and bit 14 of offset 6 then reads 1.
- R6: While armed, each write of key 0xA5C6 followed by a write of key 0xDA7E clears the counter to 0.
- R7: A write with any other key, or a 0xDA7E key that does not follow 0xA5C6, returns the sequence to waiting for 0xA5C6 and leaves the counter untouched.
- R8: Once armed, writes to offset 6 with bit 14 clear do not disarm the watchdog.
- R9: While armed, when the count equals the 64-bit period (low word at offset 4, high word at offset 5), the reset request is high for exactly one clock, one cycle later. Bit 15 of offset 6 is then set and stays set until reset.
- R10: While armed, writes to offsets 0, 1, 2, 3, 4 and 5 are ignored.
- R11: Key writes have no effect unless global-control bits 3:2 equal 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| wdt_rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The bench builds the block with its default 4-bit prescale field and 0xA5C6/0xDA7E keys. It programs prescale values of 0, 3 and 7, so the divide ratio is measured exactly over a 40-cycle window. With a period of 20 ticks at divide 1, the timeout and its exact pulse cycle fall within a few dozen clocks. Preloading the low counter word just below its wrap point makes the carry into the high word visible, which exercises the captured-high-word read.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int DW    = 32;
    localparam int CNT_W = 2 * DW;
    localparam int AW    = 3;

    localparam logic [AW-1:0] A_CTRL  = 3'd0;
    localparam logic [AW-1:0] A_GCTRL = 3'd1;
    localparam logic [AW-1:0] A_CLO   = 3'd2;
    localparam logic [AW-1:0] A_CHI   = 3'd3;
    localparam logic [AW-1:0] A_PLO   = 3'd4;
    localparam logic [AW-1:0] A_PHI   = 3'd5;
    localparam logic [AW-1:0] A_WDCTL = 3'd6;

    localparam logic [1:0] RUN_CONT = 2'd2;
    localparam logic [1:0] MODE_WDT = 2'd2;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_ARM_PEND,
        KS_ACTIVE,
        KS_SVC_PEND
    } key_state_e;
endpackage

// File: rtl/kwd_prescale.sv
module kwd_prescale #(
    parameter int PS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [PS_W-1:0] psc_i,
    output logic            tick_o
);
    typedef struct packed {
        logic [PS_W-1:0] div;
    } ps_t;

    ps_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        tick_o = 1'b0;
        if (!run_i) begin
            s_d.div = '0;
        end else if (s_q.div >= psc_i) begin
            tick_o  = 1'b1;
            s_d.div = '0;
        end else begin
            s_d.div = s_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Two ticks in a row are only possible at divide-by-one.
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && psc_i != '0 && $stable(psc_i) && run_i) |=> !tick_o);
endmodule

// File: rtl/kwd_keyfsm.sv
module kwd_keyfsm
    import kwd_pkg::*;
#(
    parameter logic [15:0] KEY_ARM = 16'hA5C6,
    parameter logic [15:0] KEY_SVC = 16'hDA7E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [15:0] key_i,
    input  logic        en_i,
    input  logic        wd_mode_i,
    output logic        armed_o,
    output logic        clr_o
);
    key_state_e st_d, st_q;

    always_comb begin
        st_d  = st_q;
        clr_o = 1'b0;
        if (wr_i) begin
            case (st_q)
                KS_IDLE: begin
                    if (wd_mode_i && en_i && key_i == KEY_ARM) st_d = KS_ARM_PEND;
                end
                KS_ARM_PEND: begin
                    if (key_i == KEY_SVC) begin
                        st_d  = KS_ACTIVE;
                        clr_o = 1'b1;
                    end else if (key_i == KEY_ARM && en_i) begin
                        st_d = KS_ARM_PEND;
                    end else begin
                        st_d = KS_IDLE;
                    end
                end
                KS_ACTIVE: begin
                    if (key_i == KEY_ARM) st_d = KS_SVC_PEND;
                end
                default: begin
                    if (key_i == KEY_SVC) begin
                        st_d  = KS_ACTIVE;
                        clr_o = 1'b1;
                    end else if (key_i != KEY_ARM) begin
                        st_d = KS_ACTIVE;
                    end
                end
            endcase
        end
    end

    assign armed_o = (st_q == KS_ACTIVE) || (st_q == KS_SVC_PEND);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= KS_IDLE;
        else        st_q <= st_d;
    end

    assert_armed_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o |=> armed_o);
    assert_clear_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |-> (wr_i && key_i == KEY_SVC));
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic             ld_lo_i,
    input  logic             ld_hi_i,
    input  logic [DW-1:0]    ld_data_i,
    input  logic             armed_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tmo_pulse_o,
    output logic             tmo_flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
        logic             flag;
    } cnt_t;

    cnt_t s_d, s_q;
    logic hit;

    always_comb begin
        s_d = s_q;
        hit = armed_i && (s_q.cnt == period_i) && !s_q.flag;
        if (clr_i)        s_d.cnt = '0;
        else if (ld_lo_i) s_d.cnt[DW-1:0] = ld_data_i;
        else if (ld_hi_i) s_d.cnt[CNT_W-1:DW] = ld_data_i;
        else if (tick_i)  s_d.cnt = s_q.cnt + 1'b1;
        s_d.pulse = hit;
        if (hit) s_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o       = s_q.cnt;
    assign tmo_pulse_o = s_q.pulse;
    assign tmo_flag_o  = s_q.flag;

    assert_service_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_flag_o |=> tmo_flag_o);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwd_pkg::*;
#(
    parameter int          PS_W    = 4,
    parameter logic [15:0] KEY_ARM = 16'hA5C6,
    parameter logic [15:0] KEY_SVC = 16'hDA7E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          wdt_rst_req
);
    localparam int PS_LSB = 8;

    typedef struct packed {
        logic [1:0]       run_mode;
        logic [1:0]       rel_en;
        logic [1:0]       tmode;
        logic [PS_W-1:0]  psc;
        logic [CNT_W-1:0] period;
        logic [DW-1:0]    snap_hi;
        logic [DW-1:0]    rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic             armed, clr, tick, run, wr_ok, key_wr, tmo_flag;
    logic [CNT_W-1:0] cnt;

    assign run    = (r_q.run_mode == RUN_CONT) && (r_q.rel_en == 2'b11);
    assign wr_ok  = bus_wr && !armed;
    assign key_wr = bus_wr && (bus_addr == A_WDCTL);

    kwd_prescale #(.PS_W(PS_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .psc_i  (r_q.psc),
        .tick_o (tick)
    );

    kwd_keyfsm #(.KEY_ARM(KEY_ARM), .KEY_SVC(KEY_SVC)) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (key_wr),
        .key_i     (bus_wdata[31:16]),
        .en_i      (bus_wdata[14]),
        .wd_mode_i (r_q.tmode == MODE_WDT),
        .armed_o   (armed),
        .clr_o     (clr)
    );

    kwd_counter u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .clr_i       (clr),
        .ld_lo_i     (wr_ok && bus_addr == A_CLO),
        .ld_hi_i     (wr_ok && bus_addr == A_CHI),
        .ld_data_i   (bus_wdata),
        .armed_i     (armed),
        .period_i    (r_q.period),
        .cnt_o       (cnt),
        .tmo_pulse_o (wdt_rst_req),
        .tmo_flag_o  (tmo_flag)
    );

    always_comb begin
        r_d = r_q;
        if (wr_ok) begin
            case (bus_addr)
                A_CTRL:  r_d.run_mode = bus_wdata[23:22];
                A_GCTRL: begin
                    r_d.rel_en = bus_wdata[1:0];
                    r_d.tmode  = bus_wdata[3:2];
                    r_d.psc    = bus_wdata[PS_LSB +: PS_W];
                end
                A_PLO:   r_d.period[DW-1:0]     = bus_wdata;
                A_PHI:   r_d.period[CNT_W-1:DW] = bus_wdata;
                default: ;
            endcase
        end
        if (bus_rd) begin
            r_d.rdata = '0;
            case (bus_addr)
                A_CTRL:  r_d.rdata[23:22] = r_q.run_mode;
                A_GCTRL: begin
                    r_d.rdata[1:0]              = r_q.rel_en;
                    r_d.rdata[3:2]              = r_q.tmode;
                    r_d.rdata[PS_LSB +: PS_W]   = r_q.psc;
                end
                A_CLO: begin
                    r_d.rdata   = cnt[DW-1:0];
                    r_d.snap_hi = cnt[CNT_W-1:DW];
                end
                A_CHI:   r_d.rdata = r_q.snap_hi;
                A_PLO:   r_d.rdata = r_q.period[DW-1:0];
                A_PHI:   r_d.rdata = r_q.period[CNT_W-1:DW];
                A_WDCTL: begin
                    r_d.rdata[15] = tmo_flag;
                    r_d.rdata[14] = armed;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;

    assert_req_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |=> !wdt_rst_req);
    assert_req_needs_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |-> armed);
    assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bus_wr && bus_addr == A_GCTRL) |=> $stable(r_q.psc));
    assert_no_tick_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_req;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    keyed_wdt u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdt_rst_req (wdt_rst_req)
    );

    localparam logic [31:0] K_ARM  = 32'hA5C6_4000;
    localparam logic [31:0] K_SVC  = 32'hDA7E_4000;
    localparam logic [31:0] RUN    = 32'h0080_0000;
    localparam logic [31:0] WD_CFG = 32'h0000_000B;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All bus tasks are entered at a falling edge and return at one.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk("R1 register zero", v, 32'h0);
        end
        chk("R1 request low", {31'b0, wdt_rst_req}, 32'h0);
    endtask

    task automatic t_stop();
        logic [31:0] v1, v2;
        do_reset();
        wr(3'd1, 32'h3);
        idle(20);
        rd(3'd2, v1);
        chk("R2 run field 0 holds", v1, 32'h0);
        wr(3'd1, 32'h1);
        wr(3'd0, RUN);
        idle(20);
        rd(3'd2, v2);
        chk("R2 half released holds", v2, 32'h0);
    endtask

    task automatic t_prescale(input logic [3:0] n, input logic [31:0] exp);
        logic [31:0] v1, v2;
        do_reset();
        wr(3'd1, 32'h3 | (32'(n) << 8));
        wr(3'd0, RUN);
        idle(5);
        rd(3'd2, v1);
        idle(39);
        rd(3'd2, v2);
        chk("R3 ticks in 40 clocks", v2 - v1, exp);
    endtask

    task automatic t_snapshot();
        logic [31:0] v;
        do_reset();
        wr(3'd1, 32'h3);
        wr(3'd3, 32'h5);
        wr(3'd2, 32'hFFFF_FFFE);
        wr(3'd0, RUN);
        rd(3'd2, v);
        chk("R4 low word", v, 32'hFFFF_FFFE);
        idle(1);
        rd(3'd3, v);
        chk("R4 captured high", v, 32'h5);
        rd(3'd2, v);
        chk("R4 low after wrap", v, 32'h1);
        rd(3'd3, v);
        chk("R4 high after wrap", v, 32'h6);
    endtask

    task automatic arm();
        wr(3'd1, WD_CFG);
        wr(3'd4, 32'd20);
        wr(3'd0, RUN);
        idle(10);
        wr(3'd6, K_ARM);
        wr(3'd6, K_SVC);
    endtask

    task automatic t_arm_service();
        logic [31:0] v;
        do_reset();
        arm();
        rd(3'd2, v);
        chk("R5 arm clears counter", v, 32'h0);
        rd(3'd6, v);
        chk("R5 enable reads 1", v, 32'h0000_4000);
        idle(7);
        wr(3'd6, K_ARM);
        wr(3'd6, K_SVC);
        rd(3'd2, v);
        chk("R6 service clears counter", v, 32'h0);
    endtask

    task automatic t_bad_keys();
        logic [31:0] v;
        do_reset();
        arm();
        wr(3'd6, K_ARM);
        wr(3'd6, 32'h1234_4000);
        wr(3'd6, K_SVC);
        rd(3'd2, v);
        chk("R7 wrong key breaks pair", v, 32'd3);
        wr(3'd6, K_ARM);
        wr(3'd6, K_SVC);
        wr(3'd6, K_SVC);
        rd(3'd2, v);
        chk("R7 lone second key no clear", v, 32'd1);
        do_reset();
        wr(3'd1, WD_CFG);
        wr(3'd6, K_ARM);
        wr(3'd6, 32'h5555_4000);
        wr(3'd6, K_SVC);
        rd(3'd6, v);
        chk("R7 broken arm stays disarmed", v, 32'h0);
    endtask

    task automatic t_sticky_lock();
        logic [31:0] v;
        do_reset();
        arm();
        wr(3'd6, 32'h0);
        wr(3'd6, 32'hFFFF_0000);
        rd(3'd6, v);
        chk("R8 enable sticky", v, 32'h0000_4000);
        wr(3'd1, 32'h0);
        rd(3'd1, v);
        chk("R10 global control locked", v, WD_CFG);
        wr(3'd0, 32'h0);
        rd(3'd0, v);
        chk("R10 control locked", v, RUN);
        wr(3'd4, 32'd99);
        rd(3'd4, v);
        chk("R10 period locked", v, 32'd20);
        wr(3'd2, 32'h00AB_0000);
        rd(3'd2, v);
        chk("R10 counter locked", v < 32'd20 ? 32'h1 : 32'h0, 32'h1);
    endtask

    task automatic t_mode_gate();
        logic [31:0] v;
        do_reset();
        wr(3'd1, 32'h3);
        wr(3'd0, RUN);
        wr(3'd6, K_ARM);
        wr(3'd6, K_SVC);
        rd(3'd6, v);
        chk("R11 keys ignored outside watchdog mode", v, 32'h0);
        idle(5);
        rd(3'd2, v);
        chk("R11 counter not cleared", v > 32'd5 ? 32'h1 : 32'h0, 32'h1);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        int first = 0;
        int highs = 0;
        do_reset();
        arm();
        for (int r = 0; r < 8; r++) begin
            idle(8);
            highs += int'(wdt_rst_req);
            wr(3'd6, K_ARM);
            wr(3'd6, K_SVC);
        end
        chk("R6 serviced no request", 32'(highs), 32'h0);
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (wdt_rst_req) begin
                highs++;
                if (first == 0) first = i;
            end
        end
        chk("R9 request cycle", 32'(first), 32'd21);
        chk("R9 request one clock", 32'(highs), 32'd1);
        rd(3'd6, v);
        chk("R9 flag set", v, 32'h0000_C000);
        wr(3'd6, K_ARM);
        wr(3'd6, K_SVC);
        rd(3'd6, v);
        chk("R9 flag sticky", v, 32'h0000_C000);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_stop();
        t_prescale(4'd3, 32'd10);
        t_prescale(4'd7, 32'd5);
        t_prescale(4'd0, 32'd40);
        t_snapshot();
        t_arm_service();
        t_bad_keys();
        t_sticky_lock();
        t_mode_gate();
        t_timeout();
        finish_run();
    end
endmodule